// File: doc/BRIEF.md
# Bit-Granular Lane Striper

This block spreads a group of bytes across several parallel serial memories one bit at a time, and gathers them back. The group of LANES bytes is treated as a matrix with one byte per row and bits numbered LSB first. In the stripe direction, the block reads that matrix column by column: bit 0 of every lane, then bit 1 of every lane, and so on. It writes the resulting bit sequence row by row into the output, filling output byte 0 from its LSB up before moving on to byte 1. The unstripe direction undoes this exactly. Data written in striped form can therefore be read back correctly when the parallel memories are later accessed one at a time.

Data enters and leaves on valid/ready streams. The direction travels with each beat, so every transfer chooses its own direction. With REGISTERED=1 (the default), an output register adds one cycle of latency and holds its contents under back-pressure. `in_ready` is high whenever the register is empty or is being drained in the same cycle. With REGISTERED=0, the block is purely combinational and passes valid and ready straight through. LANES may be 1, 2 or 4. Byte k of a bus occupies bits [8k+7:8k].

Top module: `bit_striper`

## Requirements
- R1: With `in_dir`=0 (stripe), output bit 8j+b equals input bit 8·(k mod LANES)+(k div LANES), where k=8j+b.
- R2: With `in_dir`=1 (unstripe), output bit 8·(k mod LANES)+(k div LANES) equals input bit k, for every k below 8·LANES.
- R3: Passing a group through in stripe direction and then passing the result through in unstripe direction returns the original bytes.
- R4: With LANES=1, the byte passes through unchanged in both directions.
- R5: With REGISTERED=1, a beat accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_valid`/`out_data` right after that edge.
- R6: With REGISTERED=1, while `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable and `in_ready` is low.
- R7: With REGISTERED=1, `in_ready` is high when the output register is empty or `out_ready` is high. A held beat and a new beat are swapped in the same cycle once `out_ready` rises.
- R8: The direction is taken per beat. Back-to-back beats with different `in_dir` values are each transformed in their own direction.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: With REGISTERED=0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` is the transform of the present input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take the input beat |
| in_dir | input | 1 | 0 = stripe, 1 = unstripe; sampled with the data |
| in_data | input | 8·LANES | Input bytes, lane k at bits [8k+7:8k] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 8·LANES | Transformed bytes |

## Verification
The single-byte build is swept over all 256 values in both directions, and the two-lane combinational build over all 65,536 values in both directions. These sweeps catch any lane or bit swap, including a byte-wide round-robin that would keep each byte intact. The four-lane registered build is driven with walking-one patterns, which expose any single misrouted bit, and with pseudo-random beats whose direction alternates. A design that latched the direction separately from the data would fail on the first direction change. A round trip through both directions checks that the two directions truly invert each other. A stall test holds `out_ready` low while a second beat waits, then releases it. A design that dropped or overwrote the held beat, or added a bubble on release, would show the wrong data or a low `out_valid` in the cycle checked.

// File: rtl/striper_pkg.sv
package striper_pkg;
  typedef enum logic {
    DIR_SPREAD = 1'b0,
    DIR_GATHER = 1'b1
  } stripe_dir_e;

  // Flat bit position in the lane matrix that feeds sequence slot k
  function automatic int unsigned column_src(input int unsigned k, input int unsigned lanes);
    return 8 * (k % lanes) + (k / lanes);
  endfunction
endpackage

// File: rtl/stripe_perm.sv
module stripe_perm #(
  parameter int unsigned LANES = 4,
  localparam int unsigned W = 8 * LANES
) (
  input  logic [W-1:0] din,
  input  logic         dir,
  output logic [W-1:0] dout
);
  import striper_pkg::*;

  logic [W-1:0] spread_w;
  logic [W-1:0] gather_w;

  // Both directions are pure wiring; the mapping is a bijection on W bits.
  for (genvar k = 0; k < W; k++) begin : g_slot
    localparam int unsigned SRC = column_src(k, LANES);
    assign spread_w[k]   = din[SRC];
    assign gather_w[SRC] = din[k];
  end

  assign dout = (stripe_dir_e'(dir) == DIR_GATHER) ? gather_w : spread_w;
endmodule

// File: rtl/stripe_stage.sv
module stripe_stage #(
  parameter int unsigned WIDTH = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  if (REGISTERED) begin : g_reg
    logic             full_q;
    logic [WIDTH-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
      end else if (in_ready) begin
        full_q <= in_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
      end else if (in_valid && in_ready) begin
        data_q <= in_data;
      end
    end

    // R5: accepted beat shows up after one edge
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R6: stalled beat keeps valid
    a_r6_keep_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);
    // R6: stalled beat keeps its data
    a_r6_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(out_data));
    // R7: draining with nothing new leaves the stage empty
    a_r7_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_ready) |=> !out_valid);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/bit_striper.sv
module bit_striper #(
  parameter int unsigned LANES = 4,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned W = 8 * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_dir,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] perm_w;

  stripe_perm #(.LANES(LANES)) u_perm (
    .din  (in_data),
    .dir  (in_dir),
    .dout (perm_w)
  );

  stripe_stage #(.WIDTH(W), .REGISTERED(REGISTERED)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (perm_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/tb_bit_striper.sv
module tb_bit_striper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // four-lane registered (main)
  logic        iv4, ir4, dir4, ov4, or4;
  logic [31:0] id4, od4;
  bit_striper #(.LANES(4), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv4), .in_ready(ir4), .in_dir(dir4),
    .in_data(id4), .out_valid(ov4), .out_ready(or4), .out_data(od4));

  // single-lane registered
  logic       iv1, ir1, dir1, ov1, or1;
  logic [7:0] id1, od1;
  bit_striper #(.LANES(1), .REGISTERED(1'b1)) dut_n1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .in_ready(ir1), .in_dir(dir1),
    .in_data(id1), .out_valid(ov1), .out_ready(or1), .out_data(od1));

  // two-lane combinational
  logic        iv2, ir2, dir2, ov2, or2;
  logic [15:0] id2, od2;
  bit_striper #(.LANES(2), .REGISTERED(1'b0)) dut_n2 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv2), .in_ready(ir2), .in_dir(dir2),
    .in_data(id2), .out_valid(ov2), .out_ready(or2), .out_data(od2));

  // Reference: lane e bit b occupies slot b*n+e of the column sequence.
  function automatic logic [31:0] model(input logic [31:0] x, input int n, input logic d);
    logic [31:0] r = '0;
    for (int e = 0; e < n; e++)
      for (int b = 0; b < 8; b++)
        if (!d) r[b*n+e] = x[8*e+b];
        else    r[8*e+b] = x[b*n+e];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one beat through the four-lane registered build, out_ready high
  task automatic beat4(input logic [31:0] d, input logic dr, input string req, output logic [31:0] got);
    @(negedge clk);
    iv4 = 1'b1; id4 = d; dir4 = dr; or4 = 1'b1;
    @(negedge clk);
    iv4 = 1'b0;
    chk({req, " R5 valid"}, {31'd0, ov4}, 32'd1);
    chk(req, od4, model(d, 4, dr));
    got = od4;
  endtask

  logic [31:0] lfsr = 32'hACE1_2024;
  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] g, back;
    iv4 = 0; dir4 = 0; id4 = 0; or4 = 0;
    iv1 = 0; dir1 = 0; id1 = 0; or1 = 1;
    iv2 = 0; dir2 = 0; id2 = 0; or2 = 0;
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid in reset", {31'd0, ov4}, 32'd0);
    chk("R9 in_ready in reset", {31'd0, ir4}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", {31'd0, ov4}, 32'd0);
    chk("R9 in_ready after reset", {31'd0, ir4}, 32'd1);

    // R1 / R2: walking one in both directions
    for (int i = 0; i < 32; i++) begin
      beat4(32'd1 << i, 1'b0, "R1 walk", g);
      beat4(32'd1 << i, 1'b1, "R2 walk", g);
    end
    // R8: pseudo-random beats, direction changes beat to beat
    for (int i = 0; i < 300; i++) begin
      lfsr = step(lfsr);
      beat4(lfsr, lfsr[7], "R8 mixed dir", g);
    end
    // R3: round trip
    for (int i = 0; i < 100; i++) begin
      lfsr = step(lfsr);
      beat4(lfsr, 1'b0, "R1 trip fwd", g);
      beat4(g, 1'b1, "R2 trip rev", back);
      chk("R3 round trip", back, lfsr);
    end

    // R6 / R7: back-pressure
    @(negedge clk);
    or4 = 1'b0; iv4 = 1'b1; id4 = 32'h1234_5678; dir4 = 1'b0;
    @(negedge clk);
    id4 = 32'hCAFE_F00D; dir4 = 1'b1;
    chk("R6 first beat valid", {31'd0, ov4}, 32'd1);
    chk("R6 first beat data", od4, model(32'h1234_5678, 4, 1'b0));
    chk("R6 in_ready low while stalled", {31'd0, ir4}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 held valid", {31'd0, ov4}, 32'd1);
      chk("R6 held data", od4, model(32'h1234_5678, 4, 1'b0));
    end
    or4 = 1'b1;
    #1 chk("R7 ready follows out_ready", {31'd0, ir4}, 32'd1);
    @(negedge clk);
    iv4 = 1'b0;
    chk("R7 swap valid", {31'd0, ov4}, 32'd1);
    chk("R7 swap data", od4, model(32'hCAFE_F00D, 4, 1'b1));
    @(negedge clk);
    chk("R7 drained", {31'd0, ov4}, 32'd0);

    // R4: single lane, exhaustive
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      iv1 = 1'b1; id1 = v[7:0]; dir1 = v[8];
      @(negedge clk);
      iv1 = 1'b0;
      chk("R4 single lane", {24'd0, od1}, {24'd0, v[7:0]});
    end

    // R10: combinational two-lane build, exhaustive
    for (int v = 0; v < 131072; v++) begin
      id2 = v[15:0]; dir2 = v[16]; iv2 = v[0]; or2 = v[1];
      #1;
      if (v[15:0] == 16'd0) begin
        chk("R10 valid passthrough", {31'd0, ov2}, {31'd0, v[0]});
        chk("R10 ready passthrough", {31'd0, ir2}, {31'd0, v[1]});
      end
      chk(v[16] ? "R10 R2 two lane" : "R10 R1 two lane", {16'd0, od2}, model({16'd0, v[15:0]}, 2, v[16]));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule